// File: doc/BRIEF.md
# MDIO Management Master with Ownership Handshake

This block lets host software reach the management registers of an external Ethernet PHY over a two-wire MDC/MDIO link. Software sees two 32-bit words on a simple register bus. One is a command word that holds the PHY address, the register address, a direction flag and an ownership flag. The other is a data word. Software sets the address fields and the direction in one bus write. A later write sets the ownership flag, and that hands the link to hardware and starts exactly one management frame.

The frame is a standard clause-22 transaction. The block raises MDC from the system clock through a programmable divider and shifts the frame out while MDC is low. During a read it lets go of MDIO from the turnaround onward and samples the returned bits on each rising MDC edge. When the last bit is done, hardware clears the ownership flag. For a read, the captured 16-bit value is in the data word by then. Software polls the ownership flag to know the transfer has finished.

Top module: `mdio_master`

## Requirements
- R1: After reset both register words read 0, MDC is low and the MDIO output enable is low.
- R2: The command word is at offset 0x00. Its fields are PHY address in bits 20:16, register address in bits 4:0, direction in bit 8 (1 = read, 0 = write) and ownership in bit 9. All other bits read 0. The data word is at offset 0x04, and only its low 16 bits are kept; bits 31:16 read 0.
- R3: A command write with bit 9 at 0 stores the fields and starts no frame, so MDC does not toggle.
- R4: Writing bit 9 as 1 starts a frame. Bit 9 reads 1 for the whole transfer and reads 0 once the frame has finished.
- R5: A write frame carries, MSB first, 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and the 16-bit data word. The output enable is high for all 64 bits, and MDIO changes only while MDC is low.
- R6: A read frame uses opcode 10. The output enable is high for the first 46 bits and low from the turnaround through the data phase. The 16 bits sampled on rising MDC edges, MSB first, appear in the data word when bit 9 clears.
- R7: MDC spends DIV_HALF system clocks high and DIV_HALF low in each period, and it stays low without toggling while no frame is active.
- R8: Writes to either register are ignored while bit 9 is 1, including a write in the cycle in which the frame completes.
- R9: The output enable is low after each frame and stays low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register bus access strobe |
| reg_wr | input | 1 | 1 = write access, 0 = read |
| reg_addr | input | 3 | Byte offset (0x00 command, 0x04 data) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
Two things can land in the same clock cycle: a software write and the hardware completion, which clears ownership and for reads loads the data word. The bench holds a register write on the bus in every cycle of a frame. It stops only after it sees the final falling MDC edge, so one of those writes lands exactly in the completion cycle. Afterwards the data word must hold the transmitted or captured value and the command fields must be unchanged. No second frame may start, even though the write that hit the completion cycle had the ownership bit set.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int ADDR_BITS  = 5;
  localparam int TA_HI_IDX  = 17;   // index (counting down) of first turnaround bit
  localparam int OWN_POS    = 9;
  localparam int DIR_POS    = 8;
  localparam int PHY_LSB    = 16;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef struct packed {
    logic [ADDR_BITS-1:0] phy;
    logic [ADDR_BITS-1:0] regad;
    logic                 rd;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = en && (cnt_q == LAST);
  assign rise = tick && !mdc_q;
  assign fall = tick && mdc_q;
  assign mdc  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> !mdc_q);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_master_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  mgmt_cmd_t            cmd,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 mdio_o,
  output logic                 mdio_oe
);
  localparam int IW = $clog2(FRAME_BITS);

  logic                  busy_q, busy_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [DATA_BITS-1:0]  rx_q, rx_d;
  logic                  rd_q, rd_d;

  assign busy    = busy_q;
  assign done    = busy_q && fall && (idx_q == '0);
  assign rx_data = rx_q;
  assign mdio_o  = busy_q && sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && (!rd_q || (idx_q > IW'(TA_HI_IDX)));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    rd_d   = rd_q;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        idx_d  = IW'(FRAME_BITS - 1);
        rd_d   = cmd.rd;
        rx_d   = '0;
        sh_d   = {32'hFFFF_FFFF, 2'b01, (cmd.rd ? OP_RD : OP_WR),
                  cmd.phy, cmd.regad, 2'b10, tx_data};
      end
    end else begin
      if (rise && rd_q && (idx_q < IW'(DATA_BITS)))
        rx_d = {rx_q[DATA_BITS-2:0], mdio_i};
      if (fall) begin
        if (idx_q == '0) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q - 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      rd_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      rd_q   <= rd_d;
    end
  end

  a_r9_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe);
  a_r6_no_drive_in_data: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && idx_q < IW'(DATA_BITS)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_master_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] rx_data,
  output mgmt_cmd_t            cmd,
  output logic                 owner,
  output logic [DATA_BITS-1:0] tx_data
);
  mgmt_cmd_t            cmd_q, cmd_d;
  logic                 own_q, own_d;
  logic [DATA_BITS-1:0] dat_q, dat_d;
  logic                 wr_ok;

  assign wr_ok   = reg_en && reg_wr && !own_q;
  assign cmd     = cmd_q;
  assign owner   = own_q;
  assign tx_data = dat_q;

  always_comb begin
    if (reg_addr[2])
      reg_rdata = {{(32-DATA_BITS){1'b0}}, dat_q};
    else
      reg_rdata = {11'b0, cmd_q.phy, 6'b0, own_q, cmd_q.rd, 3'b0, cmd_q.regad};
  end

  always_comb begin
    cmd_d = cmd_q;
    own_d = own_q;
    dat_d = dat_q;
    if (done) begin
      own_d = 1'b0;
      if (cmd_q.rd) dat_d = rx_data;
    end else if (wr_ok) begin
      if (reg_addr[2]) begin
        dat_d = reg_wdata[DATA_BITS-1:0];
      end else begin
        cmd_d.phy   = reg_wdata[PHY_LSB +: ADDR_BITS];
        cmd_d.regad = reg_wdata[ADDR_BITS-1:0];
        cmd_d.rd    = reg_wdata[DIR_POS];
        own_d       = reg_wdata[OWN_POS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      own_q <= 1'b0;
      dat_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      own_q <= own_d;
      dat_q <= dat_d;
    end
  end

  a_r4_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !own_q);
  a_r8_frozen_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && !done) |=> ($stable(cmd_q) && $stable(dat_q) && own_q));
  a_r3_no_owner_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    !own_q |-> !done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_en,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]           rst_sync_q;
  logic                 rst_ni;
  mgmt_cmd_t            cmd;
  logic                 owner, busy, done, rise, fall;
  logic [DATA_BITS-1:0] tx_data, rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  mdio_csr u_csr (
    .clk(clk), .rst_n(rst_ni), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done(done), .rx_data(rx_data), .cmd(cmd), .owner(owner), .tx_data(tx_data)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst_n(rst_ni), .en(busy), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_ni), .go(owner && !busy), .cmd(cmd), .tx_data(tx_data),
    .rise(rise), .fall(fall), .mdio_i(mdio_i), .busy(busy), .done(done),
    .rx_data(rx_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  a_r5_change_while_low: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(mdio_o) |-> !mdc);
  a_r4_busy_implies_owner: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> owner);
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk, rst_n, reg_en, reg_wr, mdio_i;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;
  int rises = 0, falls = 0, hi_run = 0, lo_run = 0, hi_last = 0, lo_last = 0;
  logic [63:0] got_o, got_oe;
  logic [15:0] phy_val;

  mdio_master #(.DIV_HALF(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor and PHY responder
  always @(posedge mdc) begin
    if (rises < 64) begin
      got_o[63-rises]  = mdio_o;
      got_oe[63-rises] = mdio_oe;
    end
    rises = rises + 1;
  end
  always @(negedge mdc) begin
    falls = falls + 1;
    if (rises >= 48 && rises < 64) mdio_i = phy_val[63-rises];
    else mdio_i = 1'b1;
  end
  always @(negedge clk) begin
    if (mdc) begin
      hi_run = hi_run + 1;
      if (lo_run != 0) begin lo_last = lo_run; lo_run = 0; end
    end else if (u_dut.busy || hi_run != 0) begin
      lo_run = lo_run + 1;
      if (hi_run != 0) begin hi_last = hi_run; hi_run = 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic clear_mon();
    rises = 0; falls = 0; hi_last = 0; lo_last = 0; hi_run = 0; lo_run = 0;
    got_o = '0; got_oe = '0;
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] p, input logic [4:0] r,
                                           input bit rd, input bit own);
    return {11'b0, p, 6'b0, own, rd, 3'b0, r};
  endfunction

  // hold a write on the bus every cycle until the final falling MDC edge
  task automatic hammer(input logic [2:0] a, input logic [31:0] base);
    for (int i = 0; ; i++) begin
      @(negedge clk);
      if (falls >= 64) break;
      reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = base ^ 32'(i);
    end
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(3'h0, v); chk(v == 0, "R1 command after reset", 64'(v), 0);
    bus_read(3'h4, v); chk(v == 0, "R1 data after reset", 64'(v), 0);
    chk(!mdc && !mdio_oe, "R1 mdc/oe low", {62'b0, mdc, mdio_oe}, 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    clear_mon();
    bus_write(3'h0, 32'hFFE0_FCE0 | cmd_word(5'h13, 5'h0A, 1, 0));
    bus_read(3'h0, v);
    chk(v == cmd_word(5'h13, 5'h0A, 1, 0), "R2 command fields", 64'(v),
        64'(cmd_word(5'h13, 5'h0A, 1, 0)));
    bus_write(3'h4, 32'hFFFF_FFFF);
    bus_read(3'h4, v); chk(v == 32'h0000_FFFF, "R2 data width", 64'(v), 64'h FFFF);
    repeat (40) @(negedge clk);
    chk(rises == 0 && !mdio_oe, "R3 no frame without owner", 64'(rises), 0);
  endtask

  task automatic t_write_frame();
    logic [31:0] v;
    logic [63:0] exp;
    clear_mon();
    bus_write(3'h4, 32'h0000_A5C3);
    bus_write(3'h0, cmd_word(5'h11, 5'h1B, 0, 0));
    bus_write(3'h0, cmd_word(5'h11, 5'h1B, 0, 1));
    bus_read(3'h0, v); chk(v[9] == 1'b1, "R4 owner busy", 64'(v[9]), 1);
    hammer(3'h4, 32'hDEAD_0000);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h11, 5'h1B, 2'b10, 16'hA5C3};
    chk(got_o == exp, "R5 write frame bits", got_o, exp);
    chk(got_oe == '1, "R5 oe all bits", got_oe, '1);
    chk(hi_last == DIV && lo_last == DIV, "R7 half periods",
        {32'(hi_last), 32'(lo_last)}, {32'(DIV), 32'(DIV)});
    bus_read(3'h0, v);
    chk(v == cmd_word(5'h11, 5'h1B, 0, 0), "R4 owner cleared", 64'(v),
        64'(cmd_word(5'h11, 5'h1B, 0, 0)));
    bus_read(3'h4, v); chk(v == 32'hA5C3, "R8 data write ignored", 64'(v), 64'hA5C3);
    repeat (30) @(negedge clk);
    chk(rises == 64 && !mdc, "R7 mdc idle", 64'(rises), 64);
    chk(!mdio_oe, "R9 released after write", 64'(mdio_oe), 0);
  endtask

  task automatic t_read_frame(input logic [4:0] p, input logic [4:0] r,
                              input logic [15:0] val);
    logic [31:0] v;
    logic [63:0] exp;
    clear_mon();
    phy_val = val;
    bus_write(3'h0, cmd_word(p, r, 1, 0));
    bus_write(3'h0, cmd_word(p, r, 1, 1));
    hammer(3'h0, cmd_word(~p, ~r, 0, 1));
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'b0};
    chk(got_o[63:18] == exp[63:18], "R6 read header bits", got_o, exp);
    chk(got_oe == {46'h3FFF_FFFF_FFFF, 18'b0}, "R6 oe release", got_oe,
        {46'h3FFF_FFFF_FFFF, 18'b0});
    bus_read(3'h4, v); chk(v == 32'(val), "R6 captured data", 64'(v), 64'(val));
    bus_read(3'h0, v);
    chk(v == cmd_word(p, r, 1, 0), "R8 command write ignored", 64'(v),
        64'(cmd_word(p, r, 1, 0)));
    repeat (30) @(negedge clk);
    chk(rises == 64 && !mdio_oe, "R9 released, no restart", 64'(rises), 64);
  endtask

  initial begin
    reg_en = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mdio_i = 1; phy_val = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_write_frame();
    t_read_frame(5'h03, 5'h02, 16'h3C5A);
    t_read_frame(5'h1F, 5'h00, 16'h8001);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule